// File: doc/BRIEF.md
# Synchronized Multi-Converter Sequence Trigger

This block starts the sample sequencers of a small group of converter modules (two by default). Each module has four sequencers and its own 32-bit start register on a shared register bus. Software sets request bits in that register to queue work for chosen sequencers. When several requests are pending in one module, the module passes them to the sequencer engines one at a time. The order comes from a programmable 2-bit priority per sequencer.

A module can be armed through a hold bit. While the hold bit is set, written requests are recorded but not dispatched. Writing the global start bit on any module produces a one-cycle pulse that goes to every module. On that pulse all armed modules drop their hold bit together, so their first dispatches leave in the same clock cycle. Each sequencer engine is reached through a start pulse, a busy level and a done pulse.

Address map: `addr_i = {module index, reg_sel}`. When `reg_sel = 0` the start register is selected. When `reg_sel = 1` the priority register is selected. In the priority register, bits [2s+1:2s] hold the priority of sequencer s.

Top module: `seq_trig_top`

## Requirements
- R1: After reset, every start register reads 0. Every priority register reads 0x0000_00E4, which gives sequencer s priority s. No start output is high.
- R2: Writing start-register bits [3:0] while the written hold bit (27) is 0 queues the requested sequencers. The first start pulse is one cycle wide. It goes high on the edge after the write is captured.
- R3: Among pending sequencers, the one with the lowest priority value is dispatched first. Priority 0 is the highest. On equal priority, the lower sequencer index goes first.
- R4: A module has at most one start high at a time. It raises no new start after a dispatch until the engine of the dispatched sequencer signals done.
- R5: A start-register write with bit 27 set records the requests and arms the module. An armed module raises no start.
- R6: Writing bit 31 of any start register pulses a global start. That pulse clears the hold bit of every armed module. The writing module is treated as armed for that write. All armed modules with pending requests raise their first start in the same cycle, two edges after the write is captured.
- R7: A start-register read returns only the hold bit at bit 27. The request bits, the global bit and reserved bits 30:28 and 26:4 read as 0. Writes to the reserved bits, and to priority-register bits above bit 7, have no effect.
- R8: A request for a sequencer that is already pending, being dispatched, running, or signalling busy is merged. It produces no second start.
- R9: A global start leaves unarmed modules unchanged. They dispatch only their own requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | {module index, register select} |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register (combinational) |
| seq_start_o | output | 8 | Start pulse per sequencer; bit m*4+s is for module m, sequencer s |
| seq_busy_i | input | 8 | Busy level per sequencer engine |
| seq_done_i | input | 8 | Done pulse per sequencer engine |

## Verification
The timing below counts a write as captured at edge k:
- The request becomes pending at edge k, and its start is high from edge k+1 to edge k+2.
- A global start sets its pulse at edge k and clears hold bits at edge k+1. The released starts are high after edge k+2.
- Read data is combinational and valid in the cycle the address is presented.

The bench steps a behavioural model once per clock, applying the same inputs the design sees at the next rising edge. It compares every start output and the read data on each falling edge. Any latency error of even one cycle therefore shows up as a mismatch.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;
  localparam int REG_W     = 32;
  localparam int GSYNC_BIT = 31;
  localparam int HOLD_BIT  = 27;

  typedef enum logic {
    REG_START = 1'b0,
    REG_PRIO  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/seq_trig_pick.sv
// Lowest priority value wins; ties go to the lower index (R3).
module seq_trig_pick #(
  parameter int N_SEQ = 4,
  parameter int PW    = 2,
  parameter int IDX_W = 2
) (
  input  logic [N_SEQ-1:0]    pend_i,
  input  logic [N_SEQ*PW-1:0] prio_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [PW-1:0] best_prio;

  always_comb begin
    valid_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int s = 0; s < N_SEQ; s++) begin
      if (pend_i[s] && (!valid_o || prio_i[s*PW +: PW] < best_prio)) begin
        valid_o   = 1'b1;
        idx_o     = IDX_W'(s);
        best_prio = prio_i[s*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/seq_trig_unit.sv
module seq_trig_unit
  import seq_trig_pkg::*;
#(
  parameter int N_SEQ = 4,
  parameter int PW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_start_i,
  input  logic             wr_prio_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             gsync_i,
  input  logic [N_SEQ-1:0] busy_i,
  input  logic [N_SEQ-1:0] done_i,
  output logic [REG_W-1:0] rd_start_o,
  output logic [REG_W-1:0] rd_prio_o,
  output logic [N_SEQ-1:0] start_o
);
  localparam int IDX_W  = (N_SEQ > 1) ? $clog2(N_SEQ) : 1;
  localparam int PRIO_W = N_SEQ * PW;

  logic [N_SEQ-1:0]  pend_q, pend_d, req_ok;
  logic [PRIO_W-1:0] prio_q;
  logic              hold_q;
  logic              act_q;
  logic [IDX_W-1:0]  act_idx_q;
  logic [N_SEQ-1:0]  start_q;
  logic              pick_valid;
  logic [IDX_W-1:0]  pick_idx;
  logic              launch;

  seq_trig_pick #(.N_SEQ(N_SEQ), .PW(PW), .IDX_W(IDX_W)) u_pick (
    .pend_i (pend_q),
    .prio_i (prio_q),
    .valid_o(pick_valid),
    .idx_o  (pick_idx)
  );

  // R4: dispatch only when released and no run outstanding
  assign launch = !hold_q && !act_q && pick_valid;

  // R8: requests to pending/launching/running sequencers merge
  always_comb begin
    for (int s = 0; s < N_SEQ; s++) begin
      req_ok[s] = wr_start_i && wdata_i[s] && !busy_i[s]
                  && !(act_q && act_idx_q == IDX_W'(s))
                  && !(launch && pick_idx == IDX_W'(s));
      pend_d[s] = (pend_q[s] && !(launch && pick_idx == IDX_W'(s))) || req_ok[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      hold_q    <= 1'b0;
      act_q     <= 1'b0;
      act_idx_q <= '0;
      start_q   <= '0;
      for (int s = 0; s < N_SEQ; s++) prio_q[s*PW +: PW] <= PW'(s);
    end else begin
      start_q <= '0;
      pend_q  <= pend_d;
      if (launch) begin
        start_q[pick_idx] <= 1'b1;
        act_q             <= 1'b1;
        act_idx_q         <= pick_idx;
      end else if (act_q && done_i[act_idx_q]) begin
        act_q <= 1'b0;
      end
      // R5/R6: a global write arms the writer so all release together
      if (wr_start_i)   hold_q <= wdata_i[HOLD_BIT] | wdata_i[GSYNC_BIT];
      else if (gsync_i) hold_q <= 1'b0;
      if (wr_prio_i) prio_q <= wdata_i[PRIO_W-1:0];
    end
  end

  // R7: only the hold bit is readable
  always_comb begin
    rd_start_o           = '0;
    rd_start_o[HOLD_BIT] = hold_q;
    rd_prio_o            = '0;
    rd_prio_o[PRIO_W-1:0] = prio_q;
  end

  assign start_o = start_q;
endmodule

// File: rtl/seq_trig_top.sv
module seq_trig_top
  import seq_trig_pkg::*;
#(
  parameter int N_MOD = 2,
  parameter int N_SEQ = 4,
  parameter int PW    = 2,
  localparam int MOD_W  = (N_MOD > 1) ? $clog2(N_MOD) : 1,
  localparam int ADDR_W = MOD_W + 1,
  localparam int N_ALL  = N_MOD * N_SEQ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [N_ALL-1:0]  seq_start_o,
  input  logic [N_ALL-1:0]  seq_busy_i,
  input  logic [N_ALL-1:0]  seq_done_i
);
  logic [MOD_W-1:0] mod_sel;
  reg_sel_e         reg_sel;
  logic             gsync_q;
  logic [REG_W-1:0] rd_start [N_MOD];
  logic [REG_W-1:0] rd_prio  [N_MOD];

  assign mod_sel = addr_i[ADDR_W-1:1];
  assign reg_sel = reg_sel_e'(addr_i[0]);

  // R6: one-cycle broadcast pulse, self-clearing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gsync_q <= 1'b0;
    else         gsync_q <= we_i && reg_sel == REG_START && wdata_i[GSYNC_BIT];
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    logic sel_m;
    assign sel_m = we_i && mod_sel == MOD_W'(m);

    seq_trig_unit #(.N_SEQ(N_SEQ), .PW(PW)) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_start_i(sel_m && reg_sel == REG_START),
      .wr_prio_i (sel_m && reg_sel == REG_PRIO),
      .wdata_i   (wdata_i),
      .gsync_i   (gsync_q),
      .busy_i    (seq_busy_i[m*N_SEQ +: N_SEQ]),
      .done_i    (seq_done_i[m*N_SEQ +: N_SEQ]),
      .rd_start_o(rd_start[m]),
      .rd_prio_o (rd_prio[m]),
      .start_o   (seq_start_o[m*N_SEQ +: N_SEQ])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int m = 0; m < N_MOD; m++) begin
      if (mod_sel == MOD_W'(m))
        rdata_o = (reg_sel == REG_START) ? rd_start[m] : rd_prio[m];
    end
  end
endmodule

// File: rtl/seq_trig_chk.sv
module seq_trig_chk
  import seq_trig_pkg::*;
#(
  parameter int N_MOD = 2,
  parameter int N_SEQ = 4,
  parameter int PW    = 2,
  localparam int MOD_W  = (N_MOD > 1) ? $clog2(N_MOD) : 1,
  localparam int ADDR_W = MOD_W + 1,
  localparam int N_ALL  = N_MOD * N_SEQ
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [N_ALL-1:0]  seq_start_o,
  input logic [N_ALL-1:0]  seq_done_i
);
  for (genvar j = 0; j < N_ALL; j++) begin : g_seq
    assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_start_o[j] |=> !seq_start_o[j]);
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    logic out_q;
    logic arm_wr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                out_q <= 1'b0;
      else if (|seq_start_o[m*N_SEQ +: N_SEQ])    out_q <= 1'b1;
      else if (|seq_done_i[m*N_SEQ +: N_SEQ])     out_q <= 1'b0;
    end
    assign arm_wr = we_i && addr_i[ADDR_W-1:1] == MOD_W'(m) && addr_i[0] == 1'b0
                    && wdata_i[HOLD_BIT] && !wdata_i[GSYNC_BIT];

    assert_one_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(seq_start_o[m*N_SEQ +: N_SEQ]));
    assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_q |-> seq_start_o[m*N_SEQ +: N_SEQ] == '0);
    assert_armed_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_wr |=> ##1 (seq_start_o[m*N_SEQ +: N_SEQ] == '0));
  end

  assert_start_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[0] == 1'b0) |-> ((rdata_o & ~(32'h1 << HOLD_BIT)) == '0));
endmodule

bind seq_trig_top seq_trig_chk #(.N_MOD(N_MOD), .N_SEQ(N_SEQ), .PW(PW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .seq_start_o(seq_start_o),
  .seq_done_i (seq_done_i)
);

// File: tb/seq_trig_top_bench.sv
`timescale 1ns/1ps
module seq_trig_top_bench;
  localparam int NM = 2, NS = 4, NA = 8, LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NA-1:0] seq_start_o;
  logic [NA-1:0] seq_busy_i = '0;
  logic [NA-1:0] seq_done_i = '0;

  seq_trig_top u_seq_trig_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .seq_start_o(seq_start_o), .seq_busy_i(seq_busy_i),
    .seq_done_i(seq_done_i)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done_run = 0;

  // reference model state
  bit m_pend [NM][NS];
  bit m_hold [NM];
  int m_prio [NM][NS];
  bit m_act  [NM];
  int m_aidx [NM];
  bit m_start[NA];
  bit m_gs;
  int eng_cnt[NA];

  logic [31:0] exp_rd;
  logic [NA-1:0] exp_st;
  int pick, mi, j;
  bit wr_s, wr_p, gs_cur;

  task automatic model_reset();
    for (int m = 0; m < NM; m++) begin
      m_hold[m] = 0; m_act[m] = 0; m_aidx[m] = 0;
      for (int s = 0; s < NS; s++) begin m_pend[m][s] = 0; m_prio[m][s] = s; end
    end
    for (int k = 0; k < NA; k++) begin m_start[k] = 0; eng_cnt[k] = 0; end
    m_gs = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done_run) begin
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog %s: actual hung expected finish", cur_req);
        summary();
      end
      // compare
      for (int k = 0; k < NA; k++) exp_st[k] = m_start[k];
      checks++;
      if (seq_start_o !== exp_st) begin
        errors++;
        $display("FAIL %s starts: actual %b expected %b", cur_req, seq_start_o, exp_st);
      end
      if (!we_i) begin
        mi = int'(addr_i[1]);
        exp_rd = '0;
        if (addr_i[0] == 1'b0) exp_rd[27] = m_hold[mi];
        else for (int s = 0; s < NS; s++) exp_rd[2*s +: 2] = 2'(m_prio[mi][s]);
        checks++;
        if (rdata_o !== exp_rd) begin
          errors++;
          $display("FAIL %s read addr %0d: actual %h expected %h", cur_req, addr_i, rdata_o, exp_rd);
        end
      end
      // engine stand-in
      for (int k = 0; k < NA; k++) begin
        if (seq_start_o[k]) begin seq_busy_i[k] = 1; eng_cnt[k] = LAT; seq_done_i[k] = 0; end
        else if (eng_cnt[k] > 1) begin eng_cnt[k]--; seq_done_i[k] = 0; end
        else if (eng_cnt[k] == 1) begin eng_cnt[k] = 0; seq_done_i[k] = 1; end
        else begin seq_busy_i[k] = 0; seq_done_i[k] = 0; end
      end
      // advance model to next rising edge
      gs_cur = m_gs;
      m_gs = we_i && addr_i[0] == 1'b0 && wdata_i[31];
      for (int m = 0; m < NM; m++) begin
        wr_s = we_i && int'(addr_i[1]) == m && addr_i[0] == 1'b0;
        wr_p = we_i && int'(addr_i[1]) == m && addr_i[0] == 1'b1;
        pick = -1;
        if (!m_hold[m] && !m_act[m])
          for (int s = 0; s < NS; s++)
            if (m_pend[m][s] && (pick < 0 || m_prio[m][s] < m_prio[m][pick])) pick = s;
        for (int s = 0; s < NS; s++) m_start[m*NS+s] = (s == pick);
        if (wr_s)
          for (int s = 0; s < NS; s++) begin
            j = m*NS + s;
            if (wdata_i[s] && !seq_busy_i[j] && !(m_act[m] && m_aidx[m] == s) && s != pick)
              m_pend[m][s] = 1;
          end
        if (pick >= 0) begin
          m_pend[m][pick] = 0; m_act[m] = 1; m_aidx[m] = pick;
        end else if (m_act[m] && seq_done_i[m*NS + m_aidx[m]]) m_act[m] = 0;
        if (wr_s) m_hold[m] = wdata_i[27] | wdata_i[31];
        else if (gs_cur) m_hold[m] = 0;
        if (wr_p) for (int s = 0; s < NS; s++) m_prio[m][s] = int'(wdata_i[2*s +: 2]);
      end
    end
  end

  task automatic wr(input int m, input bit sel, input logic [31:0] d);
    @(posedge clk_i); #1;
    addr_i = {m[0], sel}; we_i = 1; wdata_i = d;
    @(posedge clk_i); #1;
    we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input int m, input bit sel);
    @(posedge clk_i); #1;
    addr_i = {m[0], sel}; we_i = 0;
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1: reset values
    cur_req = "R1";
    rd(0, 0); rd(0, 1); rd(1, 0); rd(1, 1);
    // R2: single immediate request
    cur_req = "R2";
    wr(0, 0, 32'h0000_0004); idle(10);
    // R3: priorities s0=3 s1=1 s2=1 s3=0 -> order 3,1,2,0
    cur_req = "R3";
    wr(0, 1, 32'h0000_0017); rd(0, 1);
    wr(0, 0, 32'h0000_000F); idle(30);
    // R4: back-to-back dispatch in module 1
    cur_req = "R4";
    wr(1, 0, 32'h0000_0003); idle(15);
    // R8: repeated requests merge
    cur_req = "R8";
    wr(1, 0, 32'h0000_0006); wr(1, 0, 32'h0000_0006); idle(2);
    wr(1, 0, 32'h0000_0002); idle(20);
    // R5: arm both modules
    cur_req = "R5";
    wr(0, 0, 32'h0800_0005); wr(1, 0, 32'h0800_0008); idle(10);
    rd(0, 0); rd(1, 0);
    // R6: global start from module 1
    cur_req = "R6";
    wr(1, 0, 32'h8000_0000); idle(20);
    // R9: only module 0 armed
    cur_req = "R9";
    wr(0, 0, 32'h0800_0002); idle(3); wr(1, 0, 32'h8000_0000); idle(15);
    rd(1, 0);
    // R7: reserved and upper bits ignored
    cur_req = "R7";
    wr(0, 0, 32'h77FF_FFF0); rd(0, 0);
    wr(0, 1, 32'hFFFF_FFE4); rd(0, 1); idle(5);
    done_run = 1;
    summary();
  end
endmodule